// File: doc/BRIEF.md
# Receive Byte Adapter for a Dual-Mode PHY Link

This block turns the receive half of an Ethernet PHY link into a stream of bytes in the receive clock domain. The receive clock runs free at 125, 25 or 2.5 MHz, and every receive input is timed to it. A static mode input picks one of two link styles.

The first style is a double-data-rate reduced-pin link. Four data lines carry the low half of a byte on the rising edge and the high half on the falling edge of the same clock. One control line carries data-valid on the rising edge and a receive-error flag on the falling edge.

The second style is a nibble-wide single-data-rate link. One nibble arrives per clock while data-valid is high, and a separate error line flags a bad frame. The adapter pairs nibbles into bytes, holds frame errors sticky, and marks the first and last byte of each frame. Preamble and start-of-frame delimiter bytes pass through like any other byte.

Top module: `rx_byte_adapter`

## Requirements
- R1: In double-data-rate mode (mode_ddr_in=1 at reset), each valid clock yields one byte: rx_d sampled on the rising edge forms out_data[3:0] and rx_d sampled on the following falling edge forms out_data[7:4].
- R2: In double-data-rate mode, rx_ctl sampled on the rising edge is data-valid and rx_ctl sampled on the falling edge is the error flag. A byte whose falling-edge rx_ctl was high carries out_err=1.
- R3: In nibble mode (mode_ddr_in=0 at reset), the first valid nibble of each pair becomes out_data[3:0] and the second becomes out_data[7:4]. One byte appears per two valid clocks, and no two non-final bytes appear back to back.
- R4: In nibble mode, rx_d is ignored while rx_ctl (data-valid) is low. No byte is produced, and the next frame is unaffected.
- R5: In nibble mode, rx_er high while data-valid is high marks the byte holding that nibble as errored. rx_er high while data-valid is low has no effect.
- R6: In double-data-rate mode, rx_er has no effect on any output.
- R7: out_sof is high on the first byte of a frame and out_eof on its last byte. The last byte is emitted one cycle after data-valid is seen low. A one-byte frame carries both flags.
- R8: In nibble mode, a frame with an odd nibble count ends with the byte {4'h0, last nibble}, carrying out_err=1 and out_eof=1.
- R9: An error anywhere in a frame is flagged on the byte where it occurred and again on that frame's end-of-frame byte. Bytes between the two are not flagged.
- R10: The mode is taken from mode_ddr_in only while rst_n is low. Changes outside reset have no effect until the next reset.
- R11: During reset and until the first valid data arrives, out_vld, out_sof and out_eof stay low.
- R12: Every received byte, including the preamble and the 8'hD5 delimiter, appears exactly once and in order. No byte is dropped or split.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rx | input | 1 | Free-running receive clock from the PHY |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| mode_ddr_in | input | 1 | 1 = double-data-rate link, 0 = nibble link |
| rx_d | input | 4 | Receive data lines |
| rx_ctl | input | 1 | Data-valid (both modes) and, on the falling edge, error (double-data-rate mode) |
| rx_er | input | 1 | Receive error line, used in nibble mode only |
| out_data | output | 8 | Assembled byte |
| out_vld | output | 1 | out_data holds a byte this cycle |
| out_err | output | 1 | Byte is errored, or is the end of an errored frame |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |

## Verification
Start-of-frame and end-of-frame can fall on the same byte, and the error flag can land on it as well. The bench provokes this with a one-byte double-data-rate frame, a two-nibble frame, and a one-nibble frame. The one-nibble frame must come out as a single byte with out_sof, out_eof and out_err all high.

A second overlap is an error on the last byte itself, where the byte's own error and the sticky end-of-frame error coincide. The scoreboard compares data and all three flags of each byte against entries computed from the driven stimulus.

// File: rtl/rxa_pkg.sv
`timescale 1ns/1ps
package rxa_pkg;
   localparam int RXA_NIB_W  = 4;
   localparam int RXA_BYTE_W = 2 * RXA_NIB_W;

   typedef enum logic {
      RXA_MODE_NIB = 1'b0,
      RXA_MODE_DDR = 1'b1
   } rxa_mode_e;

   // one receive-clock beat after capture
   typedef struct packed {
      logic                  vld;
      logic                  err;
      logic [RXA_BYTE_W-1:0] data;
   } rxa_beat_t;

   // one emitted byte with its flags
   typedef struct packed {
      logic                  vld;
      logic                  err;
      logic                  sof;
      logic                  eof;
      logic [RXA_BYTE_W-1:0] data;
   } rxa_out_t;
endpackage

// File: rtl/rxa_capture.sv
`timescale 1ns/1ps
module rxa_capture
   import rxa_pkg::*;
#(
   parameter int NIB_W = RXA_NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rxa_mode_e        mode,
   input  logic [NIB_W-1:0] d,
   input  logic             ctl,
   input  logic             er,
   output rxa_beat_t        beat
);
   localparam int BYTE_W = 2 * NIB_W;

   logic [NIB_W-1:0] rise_w;
   logic [NIB_W-1:0] fall_w;
   logic             ctl_r_q;
   logic             ctl_f_q;
   logic             er_r_q;

   // per-lane dual-edge capture
   for (genvar i = 0; i < NIB_W; i++) begin : g_lane
      logic r_q;
      logic f_q;
      always_ff @(posedge clk) begin
         if (!rst_n) r_q <= 1'b0;
         else        r_q <= d[i];
      end
      always_ff @(negedge clk) begin
         if (!rst_n) f_q <= 1'b0;
         else        f_q <= d[i];
      end
      assign rise_w[i] = r_q;
      assign fall_w[i] = f_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_r_q <= 1'b0;
         er_r_q  <= 1'b0;
      end else begin
         ctl_r_q <= ctl;
         er_r_q  <= er;
      end
   end

   always_ff @(negedge clk) begin
      if (!rst_n) ctl_f_q <= 1'b0;
      else        ctl_f_q <= ctl;
   end

   // rising-edge sample is the low half, falling-edge sample the high half
   always_comb begin
      beat.vld = ctl_r_q;
      if (mode == RXA_MODE_DDR) begin
         beat.err  = ctl_f_q;
         beat.data = {fall_w, rise_w};
      end else begin
         beat.err  = er_r_q;
         beat.data = {{NIB_W{1'b0}}, rise_w};
      end
   end

   // R2: in double-data-rate mode a falling-edge control high during a valid beat must surface as a beat error
   a_r2_ctl_split: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RXA_MODE_DDR && ctl_r_q && ctl_f_q) |-> (beat.vld && beat.err));

   if (BYTE_W != RXA_BYTE_W) begin : g_bad_width
      $error("rxa_capture: NIB_W must match the package nibble width");
   end
endmodule

// File: rtl/rxa_assemble.sv
`timescale 1ns/1ps
module rxa_assemble
   import rxa_pkg::*;
#(
   parameter int NIB_W = RXA_NIB_W
) (
   input  logic      clk,
   input  logic      rst_n,
   input  rxa_mode_e mode,
   input  rxa_beat_t beat,
   output rxa_out_t  out
);
   localparam int BYTE_W = 2 * NIB_W;

   logic              in_frame_q;
   logic              sof_pend_q;
   logic              ferr_q;
   logic              hold_v_q;
   logic              hold_e_q;
   logic [BYTE_W-1:0] hold_d_q;
   logic              half_v_q;
   logic              half_e_q;
   logic [NIB_W-1:0]  half_d_q;
   rxa_out_t          out_q;

   assign out = out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         sof_pend_q <= 1'b0;
         ferr_q     <= 1'b0;
         hold_v_q   <= 1'b0;
         hold_e_q   <= 1'b0;
         hold_d_q   <= '0;
         half_v_q   <= 1'b0;
         half_e_q   <= 1'b0;
         half_d_q   <= '0;
         out_q      <= '0;
      end else begin
         out_q.vld <= 1'b0;
         out_q.sof <= 1'b0;
         out_q.eof <= 1'b0;
         out_q.err <= 1'b0;
         if (beat.vld) begin
            in_frame_q <= 1'b1;
            if (!in_frame_q) begin
               sof_pend_q <= 1'b1;
               ferr_q     <= beat.err;
            end else begin
               ferr_q <= ferr_q | beat.err;
            end
            if (mode == RXA_MODE_DDR) begin
               // a new full byte releases the one held before it
               if (hold_v_q) begin
                  out_q      <= '{vld: 1'b1, err: hold_e_q, sof: sof_pend_q, eof: 1'b0, data: hold_d_q};
                  sof_pend_q <= 1'b0;
               end
               hold_d_q <= beat.data;
               hold_e_q <= beat.err;
               hold_v_q <= 1'b1;
            end else if (!half_v_q) begin
               // first nibble of a pair: the held byte is known not to be last
               if (hold_v_q) begin
                  out_q      <= '{vld: 1'b1, err: hold_e_q, sof: sof_pend_q, eof: 1'b0, data: hold_d_q};
                  sof_pend_q <= 1'b0;
                  hold_v_q   <= 1'b0;
               end
               half_d_q <= beat.data[NIB_W-1:0];
               half_e_q <= beat.err;
               half_v_q <= 1'b1;
            end else begin
               hold_d_q <= {beat.data[NIB_W-1:0], half_d_q};
               hold_e_q <= half_e_q | beat.err;
               hold_v_q <= 1'b1;
               half_v_q <= 1'b0;
            end
         end else if (in_frame_q) begin
            in_frame_q <= 1'b0;
            ferr_q     <= 1'b0;
            sof_pend_q <= 1'b0;
            hold_v_q   <= 1'b0;
            half_v_q   <= 1'b0;
            if (half_v_q) begin
               out_q <= '{vld: 1'b1, err: 1'b1, sof: sof_pend_q, eof: 1'b1,
                          data: {{NIB_W{1'b0}}, half_d_q}};
            end else begin
               out_q <= '{vld: 1'b1, err: hold_e_q | ferr_q, sof: sof_pend_q, eof: 1'b1,
                          data: hold_d_q};
            end
         end
      end
   end

   // R7: a frame end is followed by at least one cycle with no byte
   a_r7_gap_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
      out_q.eof |=> !out_q.vld);

   // R8: an odd nibble left over at frame end comes out as an errored final byte
   a_r8_partial_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat.vld && in_frame_q && half_v_q) |=> (out_q.vld && out_q.eof && out_q.err));

   // R3: in nibble mode two non-final bytes are never back to back
   a_r3_nibble_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RXA_MODE_NIB && out_q.vld && !out_q.eof) |=> (!out_q.vld || out_q.eof));

   // R9: an error seen on a valid beat is still pending at the end of the frame
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (beat.vld && beat.err) |=> (ferr_q && in_frame_q));

   if (NIB_W < 1) begin : g_bad_nib
      $error("rxa_assemble: NIB_W must be at least 1");
   end
endmodule

// File: rtl/rx_byte_adapter.sv
`timescale 1ns/1ps
module rx_byte_adapter
   import rxa_pkg::*;
#(
   parameter int NIB_W = RXA_NIB_W
) (
   input  logic               clk_rx,
   input  logic               rst_n,
   input  logic               mode_ddr_in,
   input  logic [NIB_W-1:0]   rx_d,
   input  logic               rx_ctl,
   input  logic               rx_er,
   output logic [2*NIB_W-1:0] out_data,
   output logic               out_vld,
   output logic               out_err,
   output logic               out_sof,
   output logic               out_eof
);
   localparam int BYTE_W = 2 * NIB_W;

   rxa_mode_e mode_q;
   rxa_beat_t beat;
   rxa_out_t  obyte;

   // mode is frozen outside reset
   always_ff @(posedge clk_rx) begin
      if (!rst_n) mode_q <= mode_ddr_in ? RXA_MODE_DDR : RXA_MODE_NIB;
   end

   rxa_capture #(.NIB_W(NIB_W)) u_cap (
      .clk   (clk_rx),
      .rst_n (rst_n),
      .mode  (mode_q),
      .d     (rx_d),
      .ctl   (rx_ctl),
      .er    (rx_er),
      .beat  (beat)
   );

   rxa_assemble #(.NIB_W(NIB_W)) u_asm (
      .clk   (clk_rx),
      .rst_n (rst_n),
      .mode  (mode_q),
      .beat  (beat),
      .out   (obyte)
   );

   assign out_data = obyte.data;
   assign out_vld  = obyte.vld;
   assign out_err  = obyte.err;
   assign out_sof  = obyte.sof;
   assign out_eof  = obyte.eof;

   // R10: once out of reset the captured mode does not move
   a_r10_mode_frozen: assert property (@(posedge clk_rx) disable iff (!rst_n)
      rst_n |=> $stable(mode_q));

   if (NIB_W != RXA_NIB_W || BYTE_W != RXA_BYTE_W) begin : g_bad_param
      $error("rx_byte_adapter: NIB_W must equal the package nibble width");
   end
endmodule

// File: tb/sim_rx_byte_adapter.sv
`timescale 1ns/1ps
module sim_rx_byte_adapter;
   logic       clk_rx = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_ddr_in = 1'b1;
   logic [3:0] rx_d = 4'h0;
   logic       rx_ctl = 1'b0;
   logic       rx_er = 1'b0;
   logic [7:0] out_data;
   logic       out_vld, out_err, out_sof, out_eof;

   int n_checks = 0;
   int n_fail = 0;
   logic [11:0] q_exp[$];
   string       q_tag[$];

   always #4 clk_rx = ~clk_rx;

   rx_byte_adapter u0 (
      .clk_rx(clk_rx), .rst_n(rst_n), .mode_ddr_in(mode_ddr_in),
      .rx_d(rx_d), .rx_ctl(rx_ctl), .rx_er(rx_er),
      .out_data(out_data), .out_vld(out_vld), .out_err(out_err),
      .out_sof(out_sof), .out_eof(out_eof)
   );

   function automatic logic [7:0] fb(int i, int seed);
      if (i < 7) return 8'h55;
      if (i == 7) return 8'hD5;
      return 8'((i * 29 + 3) ^ seed);
   endfunction

   function automatic logic [3:0] fnib(int k, int seed);
      logic [7:0] b;
      b = fb(k / 2, seed);
      return (k % 2 == 0) ? b[3:0] : b[7:4];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] d, input bit e, input bit s, input bit f, input string tag);
      q_exp.push_back({d, e, s, f});
      q_tag.push_back(tag);
   endtask

   // scoreboard monitor: outputs move at the rising edge, sampled at the falling edge
   always @(negedge clk_rx) begin
      if (rst_n && out_vld) begin
         if (q_exp.size() == 0) begin
            chk(1'b0, "R12 unexpected byte", {out_data, out_err, out_sof, out_eof}, 0);
         end else begin
            logic [11:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk({out_data, out_err, out_sof, out_eof} == e, t,
                {out_data, out_err, out_sof, out_eof}, e);
         end
      end
   end

   task automatic do_reset(input bit ddr);
      rst_n = 1'b0;
      mode_ddr_in = ddr;
      rx_ctl = 1'b0;
      rx_er = 1'b0;
      repeat (4) @(posedge clk_rx);
      @(negedge clk_rx);
      chk(!out_vld && !out_sof && !out_eof, "R11 in reset", out_vld, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk_rx);
         chk(!out_vld && !out_sof && !out_eof, "R11 after reset", out_vld, 0);
      end
   endtask

   task automatic idle_ddr(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk_rx); #1 rx_d = 4'h3; rx_ctl = 1'b0;
         @(posedge clk_rx); #1 rx_d = 4'hC; rx_ctl = 1'b0;
      end
   endtask

   task automatic idle_nib(input int n, input bit er_junk);
      for (int i = 0; i < n; i++) begin
         @(negedge clk_rx); #1 rx_d = 4'(i * 5 + 9); rx_ctl = 1'b0; rx_er = er_junk;
      end
      @(negedge clk_rx); #1 rx_er = 1'b0;
   endtask

   task automatic drain(input string tag);
      repeat (6) @(negedge clk_rx);
      chk(q_exp.size() == 0, tag, q_exp.size(), 0);
   endtask

   task automatic ddr_frame(input int n, input int err_idx, input bit er_lvl, input int seed,
                            input string tag);
      bit anyerr;
      anyerr = (err_idx >= 0 && err_idx < n);
      for (int i = 0; i < n; i++) begin
         push(fb(i, seed), (i == err_idx) || (i == n - 1 && anyerr), i == 0, i == n - 1, tag);
      end
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = fb(i, seed);
         @(negedge clk_rx); #1 rx_d = b[3:0]; rx_ctl = 1'b1; rx_er = er_lvl;
         @(posedge clk_rx); #1 rx_d = b[7:4]; rx_ctl = (i == err_idx);
      end
      rx_er = 1'b0;
      idle_ddr(4);
      drain(tag);
   endtask

   task automatic nib_frame(input int n, input int err_idx, input bit er_idle, input int seed,
                            input string tag);
      bit anyerr;
      int nfull;
      anyerr = (err_idx >= 0 && err_idx < n);
      nfull = n / 2;
      for (int j = 0; j < nfull; j++) begin
         bit own, last;
         own  = anyerr && (err_idx / 2 == j) && (err_idx < 2 * nfull);
         last = (n % 2 == 0) && (j == nfull - 1);
         push(fb(j, seed), own || (last && anyerr), j == 0, last, tag);
      end
      if (n % 2 == 1) push({4'h0, fnib(n - 1, seed)}, 1'b1, n == 1, 1'b1, tag);
      for (int k = 0; k < n; k++) begin
         @(negedge clk_rx); #1 rx_d = fnib(k, seed); rx_ctl = 1'b1; rx_er = (k == err_idx);
      end
      idle_nib(5, er_idle);
      drain(tag);
   endtask

   bit done = 1'b0;

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset(1'b1);
      idle_ddr(2);
      ddr_frame(12, -1, 1'b0, 8'h00, "R1 R12 ddr frame with delimiter");
      ddr_frame(10, 4, 1'b0, 8'h5A, "R2 R9 ddr mid-frame error");
      ddr_frame(9, 8, 1'b0, 8'h33, "R9 ddr error on last byte");
      ddr_frame(6, -1, 1'b1, 8'h71, "R6 ddr rx_er ignored");
      ddr_frame(1, -1, 1'b0, 8'h00, "R7 ddr one-byte frame");
      mode_ddr_in = 1'b0;
      ddr_frame(5, -1, 1'b0, 8'h1C, "R10 mode change outside reset");

      do_reset(1'b0);
      idle_nib(3, 1'b0);
      nib_frame(16, -1, 1'b1, 8'h00, "R3 R4 R5 nibble pairing with idle junk");
      nib_frame(9, -1, 1'b0, 8'h42, "R8 odd nibble count");
      nib_frame(10, 5, 1'b0, 8'h27, "R5 R9 nibble error");
      nib_frame(1, -1, 1'b0, 8'h00, "R7 R8 one-nibble frame");
      nib_frame(2, 1, 1'b0, 8'h66, "R7 R9 one-byte nibble frame with error");
      mode_ddr_in = 1'b1;
      nib_frame(6, -1, 1'b0, 8'h0F, "R10 nibble mode kept");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule